// File: doc/BRIEF.md
# Receiver Idle Time-out Detector

This block watches a single serial receiver for a gap in its incoming character stream. Each received character loads a programmable tick count and arms a down-counter. When that many tick enables pass with no new character, the counter-ready status bit sets. The bit feeds an interrupt through an 8-bit mask that software can write.

A character that arrives after expiry but before software services the interrupt reloads the counter and clears counter-ready. This withdraws the interrupt. If no other interrupt source is active, the service routine's status read then returns all zeros. The block keeps this behaviour on purpose, because software written for it expects it. The other seven status bits come straight from external interrupt-source inputs. Reading the status clears counter-ready.

Top module: `rxto_idle_timer`

## Requirements
- R1: A pulse on `rx_char_i` loads the counter from `preload_i` and arms it. Counter-ready sets exactly P tick enables after the most recent character, where P is the preload value and a preload of 0 behaves as 1. A new character during the countdown starts the count again.
- R2: On expiry, `rdy_o` rises on the clock edge that consumes the final tick. Counting then stops, and `rdy_o` stays high through further ticks until something clears it.
- R3: A character arriving while `rdy_o` is high clears `rdy_o` at the next edge. The interrupt it caused is withdrawn when no other masked source is active.
- R4: After a time-out is withdrawn by a character, with every external source low, a status read returns `stat_o` = 0x00.
- R5: `stat_o` bit 3 always equals `rdy_o`. Every other bit i of `stat_o` equals `ext_src_i[i]`. `ext_src_i[3]` has no effect on any output.
- R6: `irq_o` is the OR of `stat_o & mask`. The mask loads from `mask_wdata_i` on an edge where `mask_wr_i` is high.
- R7: After reset, `rdy_o` is 0, the mask is 0 (so `irq_o` is 0), and the counter is disarmed.
- R8: A pulse on `disarm_i` disarms the counter and clears `rdy_o`. It takes priority over a character in the same cycle.
- R9: A pulse on `stat_rd_i` clears `rdy_o` at the next edge, unless an expiry happens on that same edge, in which case `rdy_o` is 1.
- R10: Tick enables have no effect while the counter is disarmed, that is, before the first character after reset or after a disarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_char_i | input | 1 | One-cycle strobe: a character was received |
| tick_i | input | 1 | Count enable, one decrement per high cycle |
| preload_i | input | 16 | Tick count loaded on each character |
| disarm_i | input | 1 | Stop the counter and clear counter-ready |
| mask_wr_i | input | 1 | Write strobe for the interrupt mask |
| mask_wdata_i | input | 8 | Mask value to write |
| stat_rd_i | input | 1 | Status read strobe, clears counter-ready |
| ext_src_i | input | 8 | Other interrupt sources (bit 3 unused) |
| rdy_o | output | 1 | Counter-ready status |
| irq_o | output | 1 | Interrupt request |
| stat_o | output | 8 | Status byte |

## Verification
The countdown is driven with several patterns:
- a clean run to expiry, which shows the exact tick on which the bit sets;
- a stream that keeps restarting the counter, which separates reload from continued counting;
- a character after expiry followed by a read, which must give 0x00 and shows the interrupt was withdrawn rather than latched;
- collisions, where disarm meets a character and a read meets expiry, which expose priority order.

A long random phase with sparse strobes and varying preloads is checked every cycle against a behavioural model. This catches off-by-one tick counts and lost set/clear races.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
   localparam int STATUS_W    = 8;
   localparam int READY_BIT   = 3;

   typedef enum logic [1:0] {
      FLAG_HOLD  = 2'd0,
      FLAG_SET   = 2'd1,
      FLAG_CLEAR = 2'd2
   } flag_op_e;

   // Priority: a restart or disarm beats expiry, expiry beats a read-clear.
   function automatic flag_op_e flag_decide(input logic restart,
                                            input logic expire,
                                            input logic rd_clear);
      if (restart)       return FLAG_CLEAR;
      else if (expire)   return FLAG_SET;
      else if (rd_clear) return FLAG_CLEAR;
      else               return FLAG_HOLD;
   endfunction
endpackage

// File: rtl/rxto_countdown.sv
module rxto_countdown #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             stop_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] preload_i,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic             last_tick;

   initial begin
      assert (CNT_W >= 2) else $error("rxto_countdown: CNT_W must be at least 2");
   end

   assign last_tick = (cnt_q <= ONE);
   assign expire_o  = armed_q & tick_i & ~load_i & ~stop_i & last_tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (stop_i) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (load_i) begin
         cnt_q   <= preload_i;
         armed_q <= 1'b1;
      end else if (armed_q && tick_i) begin
         if (last_tick) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
         end else begin
            cnt_q   <= cnt_q - ONE;
         end
      end
   end
endmodule

// File: rtl/rxto_ready_flag.sv
module rxto_ready_flag
   import rxto_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   input  logic expire_i,
   input  logic rd_clear_i,
   output logic ready_o
);
   logic     ready_q;
   flag_op_e op;

   assign op = flag_decide(restart_i, expire_i, rd_clear_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
      end else begin
         unique case (op)
            FLAG_SET:   ready_q <= 1'b1;
            FLAG_CLEAR: ready_q <= 1'b0;
            default:    ready_q <= ready_q;
         endcase
      end
   end

   assign ready_o = ready_q;
endmodule

// File: rtl/rxto_irq_merge.sv
module rxto_irq_merge #(
   parameter int STAT_W  = 8,
   parameter int RDY_BIT = 3,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ready_i,
   input  logic [STAT_W-1:0] ext_src_i,
   input  logic              mask_wr_i,
   input  logic [STAT_W-1:0] mask_wdata_i,
   output logic [STAT_W-1:0] stat_o,
   output logic              irq_o
);
   localparam logic [STAT_W-1:0] RDY_ONEHOT = STAT_W'(1) << RDY_BIT;

   logic [STAT_W-1:0] mask_q;
   logic [STAT_W-1:0] ext_kept;
   logic [STAT_W-1:0] stat_w;
   logic              irq_w;

   initial begin
      assert (RDY_BIT >= 0 && RDY_BIT < STAT_W)
         else $error("rxto_irq_merge: RDY_BIT outside status width");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         mask_q <= '0;
      else if (mask_wr_i) mask_q <= mask_wdata_i;
   end

   assign ext_kept = ext_src_i & ~RDY_ONEHOT;

   for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      if (i == RDY_BIT) begin : g_rdy
         assign stat_w[i] = ready_i;
      end else begin : g_ext
         assign stat_w[i] = ext_kept[i];
      end
   end

   assign irq_w  = |(stat_w & mask_q);
   assign stat_o = stat_w;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_w;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_w;
   end
endmodule

// File: rtl/rxto_idle_timer.sv
module rxto_idle_timer #(
   parameter int CNT_W   = 16,
   parameter int STAT_W  = rxto_pkg::STATUS_W,
   parameter int RDY_BIT = rxto_pkg::READY_BIT,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_char_i,
   input  logic              tick_i,
   input  logic [CNT_W-1:0]  preload_i,
   input  logic              disarm_i,
   input  logic              mask_wr_i,
   input  logic [STAT_W-1:0] mask_wdata_i,
   input  logic              stat_rd_i,
   input  logic [STAT_W-1:0] ext_src_i,
   output logic              rdy_o,
   output logic              irq_o,
   output logic [STAT_W-1:0] stat_o
);
   logic expire;
   logic restart;
   logic ready;

   assign restart = rx_char_i | disarm_i;

   rxto_countdown #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (rx_char_i),
      .stop_i    (disarm_i),
      .tick_i    (tick_i),
      .preload_i (preload_i),
      .expire_o  (expire)
   );

   rxto_ready_flag u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (restart),
      .expire_i   (expire),
      .rd_clear_i (stat_rd_i),
      .ready_o    (ready)
   );

   rxto_irq_merge #(
      .STAT_W  (STAT_W),
      .RDY_BIT (RDY_BIT),
      .IRQ_REG (IRQ_REG)
   ) u_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .ready_i      (ready),
      .ext_src_i    (ext_src_i),
      .mask_wr_i    (mask_wr_i),
      .mask_wdata_i (mask_wdata_i),
      .stat_o       (stat_o),
      .irq_o        (irq_o)
   );

   assign rdy_o = ready;
endmodule

// File: rtl/rxto_idle_timer_chk.sv
module rxto_idle_timer_chk #(
   parameter int STAT_W  = 8,
   parameter int RDY_BIT = 3,
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_char_i,
   input logic              tick_i,
   input logic              disarm_i,
   input logic              stat_rd_i,
   input logic              rdy_o,
   input logic              irq_o,
   input logic [STAT_W-1:0] stat_o
);
   // R3
   rx_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_char_i |=> !rdy_o);

   // R8
   disarm_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disarm_i |=> !rdy_o);

   // R9
   read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_i && !tick_i) |=> !rdy_o);

   // R2
   ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_o && !stat_rd_i && !rx_char_i && !disarm_i) |=> rdy_o);

   // R2
   ready_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_o) |-> $past(tick_i));

   // R5
   ready_in_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o[RDY_BIT] == rdy_o);

   // R6
   quiet_status_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && stat_o == '0) |-> !irq_o);
endmodule

bind rxto_idle_timer rxto_idle_timer_chk #(
   .STAT_W  (STAT_W),
   .RDY_BIT (RDY_BIT),
   .IRQ_REG (IRQ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_char_i (rx_char_i),
   .tick_i    (tick_i),
   .disarm_i  (disarm_i),
   .stat_rd_i (stat_rd_i),
   .rdy_o     (rdy_o),
   .irq_o     (irq_o),
   .stat_o    (stat_o)
);

// File: tb/rxto_idle_timer_tb.sv
module rxto_idle_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_char = 1'b0, tick = 1'b0, disarm = 1'b0;
   logic        mask_wr = 1'b0, stat_rd = 1'b0;
   logic [15:0] preload = '0;
   logic [7:0]  mask_wdata = '0, ext_src = '0;
   logic        rdy, irq;
   logic [7:0]  stat;

   int checks = 0;
   int failures = 0;

   // behavioural model state
   int       m_cnt = 0;
   bit       m_armed = 0, m_ready = 0;
   bit [7:0] m_mask = 0;

   always #4 clk = ~clk;

   rxto_idle_timer u_dut (
      .clk(clk), .rst_n(rst_n), .rx_char_i(rx_char), .tick_i(tick),
      .preload_i(preload), .disarm_i(disarm), .mask_wr_i(mask_wr),
      .mask_wdata_i(mask_wdata), .stat_rd_i(stat_rd), .ext_src_i(ext_src),
      .rdy_o(rdy), .irq_o(irq), .stat_o(stat)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic bit [7:0] m_stat();
      bit [7:0] s;
      s = ext_src;
      s[3] = m_ready;
      return s;
   endfunction

   task automatic compare_model();
      check("R2 rdy vs model", int'(rdy), int'(m_ready));
      check("R5 stat vs model", int'(stat), int'(m_stat()));
      check("R6 irq vs model", int'(irq), int'(|(m_stat() & m_mask)));
   endtask

   task automatic model_step();
      bit expire;
      expire = 0;
      if (disarm) begin
         m_cnt = 0; m_armed = 0;
      end else if (rx_char) begin
         m_cnt = int'(preload); m_armed = 1;
      end else if (m_armed && tick) begin
         if (m_cnt <= 1) begin
            m_cnt = 0; m_armed = 0; expire = 1;
         end else m_cnt = m_cnt - 1;
      end
      if (disarm || rx_char) m_ready = 0;
      else if (expire)       m_ready = 1;
      else if (stat_rd)      m_ready = 0;
      if (mask_wr) m_mask = mask_wdata;
   endtask

   // caller sets inputs at negedge, then calls cyc
   task automatic cyc();
      #1 compare_model();
      @(posedge clk);
      model_step();
      @(negedge clk);
      rx_char = 0; tick = 0; disarm = 0; mask_wr = 0; stat_rd = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1; cyc();
      end
   endtask

   task automatic expect_out(input string req, input int e_rdy, input int e_stat, input int e_irq);
      #1;
      check({req, " rdy"}, int'(rdy), e_rdy);
      check({req, " stat"}, int'(stat), e_stat);
      check({req, " irq"}, int'(irq), e_irq);
   endtask

   initial begin : watchdog
      #1600000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R7 reset state
      expect_out("R7 reset", 0, 0, 0);
      // R10 ticks before any character
      ticks(3);
      expect_out("R10 disarmed ticks", 0, 0, 0);

      mask_wdata = 8'h08; mask_wr = 1; cyc();
      preload = 16'd4; rx_char = 1; cyc();
      ticks(3);
      expect_out("R1 before expiry", 0, 0, 0);
      ticks(1);
      expect_out("R2 expiry", 1, 8'h08, 1);
      ticks(2);
      expect_out("R2 hold", 1, 8'h08, 1);
      stat_rd = 1; cyc();
      expect_out("R9 read clear", 0, 0, 0);

      preload = 16'd3; rx_char = 1; cyc();
      ticks(2);
      rx_char = 1; cyc();
      ticks(2);
      expect_out("R1 restart", 0, 0, 0);
      ticks(1);
      expect_out("R1 expiry after restart", 1, 8'h08, 1);

      rx_char = 1; cyc();
      expect_out("R3 withdraw", 0, 0, 0);
      stat_rd = 1;
      expect_out("R4 spurious read", 0, 0, 0);
      cyc();

      ext_src = 8'h0C;
      expect_out("R5 ext bit3 ignored", 0, 8'h04, 0);
      mask_wdata = 8'h04; mask_wr = 1; cyc();
      expect_out("R6 mask ext", 0, 8'h04, 1);
      ext_src = 8'h00;
      mask_wdata = 8'h08; mask_wr = 1; cyc();

      preload = 16'd2; rx_char = 1; cyc();
      ticks(1);
      disarm = 1; cyc();
      ticks(3);
      expect_out("R8 disarm stops", 0, 0, 0);
      rx_char = 1; disarm = 1; cyc();
      ticks(3);
      expect_out("R8 disarm beats char", 0, 0, 0);

      preload = 16'd0; rx_char = 1; cyc();
      ticks(1);
      expect_out("R1 preload zero", 1, 8'h08, 1);
      disarm = 1; cyc();
      expect_out("R8 disarm clears", 0, 0, 0);

      preload = 16'd1; rx_char = 1; cyc();
      tick = 1; stat_rd = 1; cyc();
      expect_out("R9 expiry beats read", 1, 8'h08, 1);

      for (int i = 0; i < 4000; i++) begin
         rx_char    = ($urandom_range(0, 19) == 0);
         tick       = ($urandom_range(0, 2) == 0);
         disarm     = ($urandom_range(0, 59) == 0);
         stat_rd    = ($urandom_range(0, 14) == 0);
         mask_wr    = ($urandom_range(0, 49) == 0);
         mask_wdata = 8'($urandom);
         preload    = 16'($urandom_range(0, 9));
         if ($urandom_range(0, 29) == 0) ext_src = 8'($urandom) & 8'h3A;
         cyc();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule